// File: doc/BRIEF.md
# Double-Buffered Configuration Bank with Frame-Synchronous Commit

This block holds the configuration of a display engine in two copies. Software writes and reads a shadow copy through a simple address/data port. The datapath sees only the active copy, which is driven out in parallel on `active_cfg`. Edits to the shadow copy therefore never reach the picture in the middle of a frame.

A control word sits at the address just past the last configuration register. It has two bits: a commit-request bit and an automatic-copy-off bit. While automatic copy is on, every rising edge of `vblank` moves the whole shadow copy into the active copy. Software normally turns automatic copy off after reset. It then collects its edits and writes the control word with both bits set. The commit-request bit reads back as 1 until the next `vblank` rising edge has performed the copy, and then drops to 0, so software can poll it to learn when the copy is done.

A read-select input switches the read port from the shadow copy to the active copy, so that a test can observe what the datapath is using.

Top module: `cfg_shadow_bank`

## Requirements
- R1: After reset every shadow register, every active register and both control bits are 0, so automatic copy is on and no commit is pending.
- R2: A write to an address below NUM_REGS changes only that shadow register. `active_cfg` changes only in a clock where a `vblank` rising edge is sampled.
- R3: `rd_data` is combinational from `addr` and `rd_active`. For an address below NUM_REGS it returns the shadow register when `rd_active`=0 and the active register when `rd_active`=1.
- R4: A transfer copies every register in a single clock: the one where `vblank`=1 is sampled after a sample of `vblank`=0. The copied values are visible on `active_cfg` after that edge.
- R5: While the automatic-copy-off bit is 0, every `vblank` rising edge performs a transfer, whether or not a commit is pending.
- R6: While the automatic-copy-off bit is 1 and no commit is pending, a `vblank` rising edge leaves `active_cfg` unchanged.
- R7: The control word is at address NUM_REGS. Bit 0 is commit-request and bit 1 is automatic-copy-off; the other bits read as 0. A write loads bit 1 directly. Writing 1 to bit 0 sets a pending commit. Writing 0 to bit 0 does not cancel a pending commit.
- R8: A pending commit reads back as bit 0 = 1 until the `vblank` rising edge that performs its transfer. From that edge on it reads 0.
- R9: A commit written while `vblank` stays high, or written in the very clock of a rising edge, is served at the following rising edge and not the current one.
- R10: When a shadow write and a transfer happen in the same clock, the active copy receives the value the shadow register held before that write, and the shadow register keeps the new value.
- R11: Writes to addresses above NUM_REGS change nothing, and reads from those addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| vblank | input | 1 | Vertical-blank level; its rising edge is the transfer point |
| wr_en | input | 1 | Write strobe for the current address |
| addr | input | ADDR_W | Register address; NUM_REGS selects the control word |
| wr_data | input | DATA_W | Write data |
| rd_active | input | 1 | Read-select: 0 reads the shadow copy, 1 reads the active copy |
| rd_data | output | DATA_W | Combinational read data |
| active_cfg | output | NUM_REGS*DATA_W | Active copy of all registers; register i is at bits i*DATA_W and up |

## Verification
The directed cases each isolate one route into the active copy:
- an autoload edge right after reset;
- an edge with automatic copy off, which must change nothing;
- a polled commit that clears at its edge;
- a zero write that must not cancel a pending commit;
- a commit issued while `vblank` is held high, and another issued in the edge clock itself, both of which must wait one more edge;
- a shadow write that collides with a transfer, which tells a pre-write copy from a post-write copy.

After that, random mixes of writes, control words, out-of-range addresses and irregular `vblank` waveforms are compared clock by clock against a bench model. Each clock compares `active_cfg` and a read of either copy. This separates a copy made at the wrong edge from a copy that misses or mixes registers.

// File: rtl/cfgsb_pkg.sv
package cfgsb_pkg;

    localparam int LOAD_BIT = 0;
    localparam int AOFF_BIT = 1;

    typedef struct packed {
        logic aoff;
        logic load;
    } cfgsb_ctrl_t;

endpackage

// File: rtl/cfgsb_edge.sv
module cfgsb_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic vblank,
    output logic rise
);
    typedef struct packed {
        logic vb;
    } edge_t;

    edge_t s_d, s_q;

    always_comb begin
        s_d    = s_q;
        s_d.vb = vblank;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign rise = vblank & ~s_q.vb;
endmodule

// File: rtl/cfgsb_ctrl.sv
module cfgsb_ctrl
    import cfgsb_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        rise,
    input  logic        ctrl_wr,
    input  logic        wr_load,
    input  logic        wr_aoff,
    output logic        xfer,
    output cfgsb_ctrl_t ctrl
);
    cfgsb_ctrl_t c_d, c_q;

    // a pending commit or enabled autoload arms the edge
    assign xfer = rise & (~c_q.aoff | c_q.load);

    always_comb begin
        c_d = c_q;
        if (rise && c_q.load) c_d.load = 1'b0;
        if (ctrl_wr) begin
            c_d.aoff = wr_aoff;
            if (wr_load) c_d.load = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign ctrl = c_q;
endmodule

// File: rtl/cfgsb_bank.sv
module cfgsb_bank #(
    parameter int NUM_REGS = 8,
    parameter int DATA_W   = 32,
    localparam int IDX_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             wr_en,
    input  logic [IDX_W-1:0]                 wr_idx,
    input  logic [DATA_W-1:0]                wr_data,
    input  logic                             xfer,
    output logic [NUM_REGS-1:0][DATA_W-1:0]  shadow,
    output logic [NUM_REGS-1:0][DATA_W-1:0]  active
);
    typedef struct packed {
        logic [NUM_REGS-1:0][DATA_W-1:0] sh;
        logic [NUM_REGS-1:0][DATA_W-1:0] ac;
    } bank_t;

    bank_t b_d, b_q;

    always_comb begin
        b_d = b_q;
        // transfer takes the pre-write shadow contents
        if (xfer) b_d.ac = b_q.sh;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (wr_en && (wr_idx == IDX_W'(i))) b_d.sh[i] = wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) b_q <= '0;
        else        b_q <= b_d;
    end

    assign shadow = b_q.sh;
    assign active = b_q.ac;
endmodule

// File: rtl/cfg_shadow_bank.sv
module cfg_shadow_bank
    import cfgsb_pkg::*;
#(
    parameter int NUM_REGS = 8,
    parameter int DATA_W   = 32,
    localparam int ADDR_W  = $clog2(NUM_REGS + 1),
    localparam int IDX_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        vblank,
    input  logic                        wr_en,
    input  logic [ADDR_W-1:0]           addr,
    input  logic [DATA_W-1:0]           wr_data,
    input  logic                        rd_active,
    output logic [DATA_W-1:0]           rd_data,
    output logic [NUM_REGS*DATA_W-1:0]  active_cfg
);
    localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(NUM_REGS);

    logic                            rise;
    logic                            xfer;
    logic                            in_bank;
    logic                            ctrl_sel;
    logic                            load_q;
    logic                            aoff_q;
    cfgsb_ctrl_t                     ctrl;
    logic [NUM_REGS-1:0][DATA_W-1:0] shadow;
    logic [NUM_REGS-1:0][DATA_W-1:0] active;
    logic [IDX_W-1:0]                idx;

    assign in_bank  = (addr < CTRL_ADDR);
    assign ctrl_sel = (addr == CTRL_ADDR);
    assign idx      = IDX_W'(addr);

    cfgsb_edge u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .vblank (vblank),
        .rise   (rise)
    );

    cfgsb_ctrl u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .rise    (rise),
        .ctrl_wr (wr_en & ctrl_sel),
        .wr_load (wr_data[LOAD_BIT]),
        .wr_aoff (wr_data[AOFF_BIT]),
        .xfer    (xfer),
        .ctrl    (ctrl)
    );

    cfgsb_bank #(
        .NUM_REGS (NUM_REGS),
        .DATA_W   (DATA_W)
    ) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en & in_bank),
        .wr_idx  (idx),
        .wr_data (wr_data),
        .xfer    (xfer),
        .shadow  (shadow),
        .active  (active)
    );

    assign load_q = ctrl.load;
    assign aoff_q = ctrl.aoff;

    always_comb begin
        rd_data = '0;
        if (in_bank) begin
            rd_data = rd_active ? active[idx] : shadow[idx];
        end else if (ctrl_sel) begin
            rd_data[LOAD_BIT] = load_q;
            rd_data[AOFF_BIT] = aoff_q;
        end
    end

    assign active_cfg = active;
endmodule

// File: rtl/cfg_shadow_bank_chk.sv
module cfg_shadow_bank_chk #(
    parameter int NUM_REGS = 8,
    parameter int DATA_W   = 32,
    parameter int ADDR_W   = 4
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       vblank,
    input logic                       wr_en,
    input logic [ADDR_W-1:0]          addr,
    input logic                       wr_load,
    input logic                       wr_aoff,
    input logic [NUM_REGS*DATA_W-1:0] active_cfg,
    input logic                       load_q,
    input logic                       aoff_q
);
    logic vb_seen;
    logic edge_now;
    logic ctrl_hit;

    always_ff @(posedge clk) begin
        if (!rst_n) vb_seen <= 1'b0;
        else        vb_seen <= vblank;
    end

    assign edge_now = vblank & ~vb_seen;
    assign ctrl_hit = wr_en & (addr == ADDR_W'(NUM_REGS));

    // R2 / R4: the active copy moves only at a vblank rising edge
    a_r2_active_only_at_edge: assert property (@(posedge clk) disable iff (!rst_n)
        !edge_now |=> $stable(active_cfg));

    // R6: automatic copy off and nothing pending -> no transfer
    a_r6_no_copy_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_now && aoff_q && !load_q) |=> $stable(active_cfg));

    // R8: a pending commit clears at the edge that serves it
    a_r8_commit_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_now && load_q && !(ctrl_hit && wr_load)) |=> !load_q);

    // R8 / R9: a pending commit survives until an edge
    a_r8_commit_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (load_q && !edge_now) |=> load_q);

    // R7: the copy-off bit follows the written value
    a_r7_aoff_written: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_hit |=> (aoff_q == $past(wr_aoff)));
endmodule

bind cfg_shadow_bank cfg_shadow_bank_chk #(
    .NUM_REGS (NUM_REGS),
    .DATA_W   (DATA_W),
    .ADDR_W   (ADDR_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .vblank     (vblank),
    .wr_en      (wr_en),
    .addr       (addr),
    .wr_load    (wr_data[0]),
    .wr_aoff    (wr_data[1]),
    .active_cfg (active_cfg),
    .load_q     (load_q),
    .aoff_q     (aoff_q)
);

// File: tb/cfg_shadow_bank_bench.sv
module cfg_shadow_bank_bench;
    localparam int N  = 8;
    localparam int W  = 32;
    localparam int AW = 4;
    localparam int FW = N * W;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          vblank = 1'b0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [W-1:0]  wr_data = '0;
    logic          rd_active = 1'b0;
    logic [W-1:0]  rd_data;
    logic [FW-1:0] active_cfg;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    logic [W-1:0] m_sh [N];
    logic [W-1:0] m_ac [N];
    logic         m_load, m_aoff, m_vbq;

    always #4 clk = ~clk;

    cfg_shadow_bank u_cfg_shadow_bank (
        .clk(clk), .rst_n(rst_n), .vblank(vblank), .wr_en(wr_en),
        .addr(addr), .wr_data(wr_data), .rd_active(rd_active),
        .rd_data(rd_data), .active_cfg(active_cfg)
    );

    function automatic logic [FW-1:0] m_flat();
        logic [FW-1:0] f;
        for (int i = 0; i < N; i++) f[i*W +: W] = m_ac[i];
        return f;
    endfunction

    function automatic logic [W-1:0] m_read(input logic [AW-1:0] a, input logic sel);
        logic [W-1:0] r = '0;
        if (a < AW'(N)) r = sel ? m_ac[a] : m_sh[a];
        else if (a == AW'(N)) begin r[0] = m_load; r[1] = m_aoff; end
        return r;
    endfunction

    task automatic chk(input string tag, input logic [FW-1:0] act, input logic [FW-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic m_reset();
        for (int i = 0; i < N; i++) begin m_sh[i] = '0; m_ac[i] = '0; end
        m_load = 0; m_aoff = 0; m_vbq = 0;
    endtask

    // one clock: drive at negedge, update the model, land at next negedge
    task automatic step(input logic we, input logic [AW-1:0] a,
                        input logic [W-1:0] d, input logic vb);
        logic rise, xfer;
        wr_en = we; addr = a; wr_data = d; vblank = vb;
        rise = vb && !m_vbq;
        xfer = rise && (!m_aoff || m_load);
        if (xfer) for (int i = 0; i < N; i++) m_ac[i] = m_sh[i];
        if (rise && m_load) m_load = 0;
        if (we && a < AW'(N)) m_sh[a] = d;
        if (we && a == AW'(N)) begin
            m_aoff = d[1];
            if (d[0]) m_load = 1;
        end
        m_vbq = vb;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input logic [AW-1:0] a, input logic sel);
        addr = a; rd_active = sel;
        #1;
        chk(tag, FW'(rd_data), FW'(m_read(a, sel)));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic vbr;
        void'($urandom(32'd20240611));
        m_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        chk("R1 active after reset", active_cfg, '0);
        rd_chk("R1 control after reset", AW'(N), 0);
        rd_chk("R1 shadow reg0 after reset", 0, 0);

        // R2 / R3 shadow write stays out of active copy
        step(1, 3, 32'hA5A5_0003, 0);
        rd_chk("R3 shadow read", 3, 0);
        rd_chk("R2 active untouched by write", 3, 1);
        chk("R2 active bus unchanged", active_cfg, m_flat());

        // R5 autoload after reset, R4 single-clock copy
        step(1, 6, 32'h0000_0066, 1);
        chk("R5 autoload edge copies", active_cfg, m_flat());
        rd_chk("R4 reg3 active after edge", 3, 1);
        rd_chk("R10 reg6 written in edge clock stays out", 6, 1);

        // R6 copy off, no commit
        step(0, 0, 0, 0);
        step(1, AW'(N), 32'h2, 0);
        step(1, 3, 32'h1111_1111, 0);
        step(0, 0, 0, 1);
        rd_chk("R6 no copy when off", 3, 1);
        rd_chk("R7 control reads copy-off", AW'(N), 0);

        // R8 polled commit
        step(0, 0, 0, 0);
        step(1, AW'(N), 32'h3, 0);
        rd_chk("R8 commit reads pending", AW'(N), 0);
        step(0, 0, 0, 0);
        rd_chk("R8 commit still pending", AW'(N), 0);
        step(0, 0, 0, 1);
        chk("R4 commit edge copies", active_cfg, m_flat());
        rd_chk("R8 commit cleared", AW'(N), 0);

        // R7 zero write does not cancel
        step(0, 0, 0, 0);
        step(1, AW'(N), 32'h3, 0);
        step(1, AW'(N), 32'h2, 0);
        rd_chk("R7 zero write keeps commit", AW'(N), 0);
        step(1, 1, 32'hBEEF_0001, 0);
        step(0, 0, 0, 1);
        rd_chk("R7 kept commit served", 1, 1);

        // R9 commit while vblank held high
        step(1, 2, 32'h2222_0002, 1);
        step(1, AW'(N), 32'h3, 1);
        step(0, 0, 0, 1);
        rd_chk("R9 no copy while high", 2, 1);
        step(0, 0, 0, 0);
        step(0, 0, 0, 1);
        rd_chk("R9 copy at next rise", 2, 1);

        // R10 write colliding with commit transfer
        step(0, 0, 0, 0);
        step(1, 5, 32'h5555_0000, 0);
        step(1, AW'(N), 32'h3, 0);
        step(1, 5, 32'h5555_9999, 1);
        rd_chk("R10 active has pre-write value", 5, 1);
        rd_chk("R10 shadow has new value", 5, 0);

        // R9 commit written in the edge clock itself
        step(0, 0, 0, 0);
        step(1, AW'(N), 32'h3, 1);
        rd_chk("R9 edge-clock commit pending", AW'(N), 0);
        rd_chk("R9 edge-clock commit no copy", 5, 1);
        step(0, 0, 0, 0);
        step(0, 0, 0, 1);
        rd_chk("R9 served at following edge", 5, 1);

        // R11 out of range
        step(1, 12, 32'hFFFF_FFFF, 0);
        rd_chk("R11 out-of-range read", 12, 0);
        for (int i = 0; i < N; i++) rd_chk("R11 bank untouched", AW'(i), 0);
        rd_chk("R11 control untouched", AW'(N), 0);

        // random mix
        vbr = 0;
        for (int k = 0; k < 3000; k++) begin
            logic [AW-1:0] ra;
            logic [W-1:0]  rdat;
            ra = AW'($urandom % 16);
            if ($urandom % 4 == 0) ra = AW'(N);
            rdat = $urandom;
            if ($urandom % 6 == 0) vbr = ~vbr;
            step(($urandom % 2) == 1, ra, rdat, vbr);
            chk("R4 random active bus", active_cfg, m_flat());
            rd_chk("R3 random read", AW'($urandom % 16), ($urandom % 2) == 1);
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule